// File: doc/BRIEF.md
# Parallel LCD Command/Data Write Driver

This block sits between a display-update engine and a panel controller that uses a parallel write interface with separate chip-select, register-select, write and read strobes and a 16-bit bus. The caller offers a nonzero command code, the number of parameter or pixel words that follow it, and the first word. The block then runs one transaction. First comes a command write cycle with register-select low. Then comes one data write cycle per word with register-select high. The count may be as large as a full frame of pixels, so a whole screen can be streamed behind a single memory-write command.

For every word it takes, the block pulses a one-cycle `sent_o` handshake, and the caller then puts the next word on `data_i`. While the final counted word is on the bus, `last_o` is high. `busy_o` and chip-select stay active from the command cycle until the caller returns the command input to zero. After reset the block drives the panel reset low for a set number of clocks and ignores any command during that window.

The control is one state machine with these states:
- `S_PWRUP`: panel reset is held low.
- `S_IDLE`: waits for a nonzero command.
- `S_CMD_LO` and `S_CMD_HI`: the low and high phases of the command strobe.
- `S_DAT_LO` and `S_DAT_HI`: the low and high phases of each data strobe.
- `S_HOLD`: waits for the command to be cleared.

Its transitions are:
- `S_PWRUP` to `S_IDLE` when the power-up count ends.
- `S_IDLE` to `S_CMD_LO` on a nonzero command.
- Each low state to its high state when the low phase expires.
- `S_CMD_HI` to `S_DAT_LO` when words remain, or to `S_HOLD` when the count is zero.
- `S_DAT_HI` to `S_DAT_LO` when more words remain, or to `S_HOLD` after the final word.
- `S_HOLD` to `S_IDLE` when the command input reads zero.

Top module: `lcd_cmd_driver`

## Requirements
- R1: After reset is released, `lcd_on_o` is high from the first clock edge, and `lcd_rst_n_o` stays low for exactly `RST_CYCLES` clocks (default 12). No write strobe occurs and `busy_o` stays low while `lcd_rst_n_o` is low, even if a command is presented.
- R2: When idle, `lcd_cs_n_o` and `lcd_wr_n_o` are high and `busy_o` is low. A command value of 0 starts nothing. `lcd_rd_n_o` is high at all times.
- R3: In the idle state, a nonzero `cmd_i` raises `busy_o` at the next clock edge. The first write cycle carries register-select low and the bus value equal to the command, zero-extended to 16 bits.
- R4: After the command cycle, exactly `len_i` data write cycles follow. Each has register-select high, and they carry the presented words in order.
- R5: Each write strobe is low for at least 2 clocks, and the bus is stable throughout. Between write cycles the strobe is high for at least 2 clocks.
- R6: `sent_o` pulses for one clock per data word, in the last low clock of that word's strobe. The word is captured when its strobe begins, so the caller may change `data_i` after the pulse.
- R7: `last_o` is high only while the final counted word is being written, including at that word's `sent_o` pulse.
- R8: `lcd_cs_n_o` is low for the whole transaction, from the command cycle until `busy_o` falls.
- R9: After the final write, the block stays busy with chip-select low while `cmd_i` is nonzero, and a held command does not start a new transaction. `busy_o` falls at the clock edge after `cmd_i` reads 0.
- R10: A transaction with `len_i` = 0 consists only of the command cycle. `last_o` and `sent_o` never assert during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmd_i | input | 8 | Command code; nonzero starts a transaction, 0 ends it |
| len_i | input | 17 | Number of data words after the command |
| data_i | input | 16 | Current data word |
| sent_o | output | 1 | One-clock pulse per data word taken |
| last_o | output | 1 | Final counted word is being written |
| busy_o | output | 1 | Transaction in progress |
| lcd_on_o | output | 1 | Panel power enable |
| lcd_rst_n_o | output | 1 | Panel reset, active low |
| lcd_cs_n_o | output | 1 | Panel chip select, active low |
| lcd_rs_o | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_n_o | output | 1 | Write strobe, active low |
| lcd_rd_n_o | output | 1 | Read strobe, held high |
| lcd_db_o | output | 16 | Panel data bus |

## Verification
All panel pins and handshakes are decoded from registered state, so each result is due one clock after the event that causes it:
- `busy_o`, chip-select and the falling command strobe appear one clock after a nonzero command is sampled in idle.
- `busy_o` falls one clock after a zero command is sampled in `S_HOLD`.
- The strobe rises one clock after each `sent_o` pulse.

The bench drives inputs and samples outputs on falling edges, so every such check lands exactly one sample after its stimulus. A falling-edge monitor rebuilds the written stream at each strobe rise and measures the low and high widths. Those results are compared against word lists the bench generates itself once `busy_o` is seen in the hold phase.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    typedef enum logic [2:0] {
        S_PWRUP,
        S_IDLE,
        S_CMD_LO,
        S_CMD_HI,
        S_DAT_LO,
        S_DAT_HI,
        S_HOLD
    } drv_state_e;

endpackage

// File: rtl/lcd_pwrup_seq.sv
// Counts clocks after reset release; ready_o rises after CYCLES-1 clocks.
module lcd_pwrup_seq #(
    parameter int CYCLES = 12
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic ready_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (!ready_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready_o = (cnt_q == CW'(CYCLES - 1));
endmodule

// File: rtl/lcd_phase_timer.sv
// Measures the length of one strobe phase; restarts after each expiry.
module lcd_phase_timer #(
    parameter int LO_CYCLES = 2,
    parameter int HI_CYCLES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic sel_hi_i,
    output logic expired_o
);
    localparam int MAXC = (LO_CYCLES > HI_CYCLES) ? LO_CYCLES : HI_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit     = sel_hi_i ? CW'(HI_CYCLES - 1) : CW'(LO_CYCLES - 1);
    assign expired_o = run_i && (cnt_q == limit);

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i || expired_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_word_counter.sv
// Holds the number of data words still to be written.
module lcd_word_counter #(
    parameter int LEN_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dec_i,
    output logic             zero_o,
    output logic             one_o
);
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= len_i;
        end else if (dec_i && !zero_o) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign zero_o = (rem_q == '0);
    assign one_o  = (rem_q == LEN_W'(1));
endmodule

// File: rtl/lcd_cmd_driver.sv
module lcd_cmd_driver
    import lcd_drv_pkg::*;
#(
    parameter int CMD_W      = 8,
    parameter int DATA_W     = 16,
    parameter int LEN_W      = 17,
    parameter int RST_CYCLES = 12,
    parameter int LO_CYCLES  = 2,
    parameter int HI_CYCLES  = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              sent_o,
    output logic              last_o,
    output logic              busy_o,
    output logic              lcd_on_o,
    output logic              lcd_rst_n_o,
    output logic              lcd_cs_n_o,
    output logic              lcd_rs_o,
    output logic              lcd_wr_n_o,
    output logic              lcd_rd_n_o,
    output logic [DATA_W-1:0] lcd_db_o
);
    drv_state_e state_q, state_d;

    logic pwr_ready;
    logic ph_run, ph_hi, ph_exp;
    logic cnt_load, cnt_dec, rem_zero, rem_one;
    logic start;
    logic on_q;
    logic [DATA_W-1:0] db_q;

    lcd_pwrup_seq #(.CYCLES(RST_CYCLES)) u_pwr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ready_o (pwr_ready)
    );

    lcd_phase_timer #(.LO_CYCLES(LO_CYCLES), .HI_CYCLES(HI_CYCLES)) u_phase (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (ph_run),
        .sel_hi_i  (ph_hi),
        .expired_o (ph_exp)
    );

    lcd_word_counter #(.LEN_W(LEN_W)) u_words (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (cnt_load),
        .len_i  (len_i),
        .dec_i  (cnt_dec),
        .zero_o (rem_zero),
        .one_o  (rem_one)
    );

    assign start    = (state_q == S_IDLE) && (cmd_i != '0);
    assign cnt_load = start;
    assign cnt_dec  = (state_q == S_DAT_HI) && ph_exp;
    assign ph_run   = (state_q == S_CMD_LO) || (state_q == S_CMD_HI) ||
                      (state_q == S_DAT_LO) || (state_q == S_DAT_HI);
    assign ph_hi    = (state_q == S_CMD_HI) || (state_q == S_DAT_HI);

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= S_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_PWRUP:  if (pwr_ready) state_d = S_IDLE;
            S_IDLE:   if (start) state_d = S_CMD_LO;
            S_CMD_LO: if (ph_exp) state_d = S_CMD_HI;
            S_CMD_HI: if (ph_exp) state_d = rem_zero ? S_HOLD : S_DAT_LO;
            S_DAT_LO: if (ph_exp) state_d = S_DAT_HI;
            S_DAT_HI: if (ph_exp) state_d = rem_one ? S_HOLD : S_DAT_LO;
            S_HOLD:   if (cmd_i == '0) state_d = S_IDLE;
            default:  state_d = S_PWRUP;
        endcase
    end

    // bus capture: command on start, each word as its strobe begins
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            db_q <= '0;
            on_q <= 1'b0;
        end else begin
            on_q <= 1'b1;
            if (start) begin
                db_q <= DATA_W'(cmd_i);
            end else if (state_d == S_DAT_LO && state_q != S_DAT_LO) begin
                db_q <= data_i;
            end
        end
    end

    // output decode
    always_comb begin
        lcd_rst_n_o = (state_q != S_PWRUP);
        lcd_on_o    = on_q;
        lcd_rd_n_o  = 1'b1;
        lcd_db_o    = db_q;
        lcd_cs_n_o  = 1'b1;
        lcd_wr_n_o  = 1'b1;
        lcd_rs_o    = 1'b0;
        busy_o      = 1'b0;
        sent_o      = 1'b0;
        last_o      = 1'b0;
        unique case (state_q)
            S_PWRUP, S_IDLE: ;
            S_CMD_LO: begin
                busy_o = 1'b1; lcd_cs_n_o = 1'b0; lcd_wr_n_o = 1'b0;
            end
            S_CMD_HI, S_HOLD: begin
                busy_o = 1'b1; lcd_cs_n_o = 1'b0;
            end
            S_DAT_LO: begin
                busy_o = 1'b1; lcd_cs_n_o = 1'b0; lcd_wr_n_o = 1'b0;
                lcd_rs_o = 1'b1; sent_o = ph_exp; last_o = rem_one;
            end
            S_DAT_HI: begin
                busy_o = 1'b1; lcd_cs_n_o = 1'b0;
                lcd_rs_o = 1'b1; last_o = rem_one;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lcd_cmd_driver_chk.sv
module lcd_cmd_driver_chk #(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [CMD_W-1:0]  cmd_i,
    input logic              sent_o,
    input logic              last_o,
    input logic              busy_o,
    input logic              lcd_rst_n_o,
    input logic              lcd_cs_n_o,
    input logic              lcd_rs_o,
    input logic              lcd_wr_n_o,
    input logic              lcd_rd_n_o,
    input logic [DATA_W-1:0] lcd_db_o
);
    a_r2_read_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        lcd_rd_n_o);

    a_r1_quiet_in_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        !lcd_rst_n_o |-> (lcd_wr_n_o && !busy_o));

    a_r8_cs_on_write: assert property (@(posedge clk_i) disable iff (rst_i)
        !lcd_wr_n_o |-> (!lcd_cs_n_o && busy_o));

    a_r5_low_width: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(lcd_wr_n_o) |=> !lcd_wr_n_o);

    a_r5_high_width: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lcd_wr_n_o) |=> lcd_wr_n_o);

    a_r5_bus_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        (!lcd_wr_n_o && !$past(lcd_wr_n_o)) |-> $stable(lcd_db_o));

    a_r6_sent_ends_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        sent_o |-> (!lcd_wr_n_o && lcd_rs_o) ##1 lcd_wr_n_o);

    a_r7_last_in_data: assert property (@(posedge clk_i) disable iff (rst_i)
        last_o |-> (busy_o && lcd_rs_o));

    a_r9_hold_while_cmd: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && cmd_i != '0) |=> busy_o);

    a_r3_start: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && lcd_rst_n_o && $past(lcd_rst_n_o) && cmd_i != '0) |=> (busy_o && !lcd_rs_o));
endmodule

bind lcd_cmd_driver lcd_cmd_driver_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cmd_i       (cmd_i),
    .sent_o      (sent_o),
    .last_o      (last_o),
    .busy_o      (busy_o),
    .lcd_rst_n_o (lcd_rst_n_o),
    .lcd_cs_n_o  (lcd_cs_n_o),
    .lcd_rs_o    (lcd_rs_o),
    .lcd_wr_n_o  (lcd_wr_n_o),
    .lcd_rd_n_o  (lcd_rd_n_o),
    .lcd_db_o    (lcd_db_o)
);

// File: tb/sim_lcd_cmd_driver.sv
`timescale 1ns/1ps
module sim_lcd_cmd_driver;
    localparam int RST_CYCLES = 12;
    localparam int LO_CYCLES  = 2;
    localparam int HI_CYCLES  = 2;
    localparam int CAP        = 4096;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [7:0]  cmd_i = '0;
    logic [16:0] len_i = '0;
    logic [15:0] data_i = '0;
    logic sent_o, last_o, busy_o, lcd_on_o, lcd_rst_n_o, lcd_cs_n_o;
    logic lcd_rs_o, lcd_wr_n_o, lcd_rd_n_o;
    logic [15:0] lcd_db_o;

    always #4 clk_i = ~clk_i;

    lcd_cmd_driver #(.RST_CYCLES(RST_CYCLES), .LO_CYCLES(LO_CYCLES),
                     .HI_CYCLES(HI_CYCLES)) u0 (
        .clk_i(clk_i), .rst_i(rst_i), .cmd_i(cmd_i), .len_i(len_i),
        .data_i(data_i), .sent_o(sent_o), .last_o(last_o), .busy_o(busy_o),
        .lcd_on_o(lcd_on_o), .lcd_rst_n_o(lcd_rst_n_o),
        .lcd_cs_n_o(lcd_cs_n_o), .lcd_rs_o(lcd_rs_o),
        .lcd_wr_n_o(lcd_wr_n_o), .lcd_rd_n_o(lcd_rd_n_o),
        .lcd_db_o(lcd_db_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit in_rst = 1'b1;

    logic        cap_rs [CAP];
    logic [15:0] cap_db [CAP];
    int          cap_n = 0;
    logic [15:0] wbuf [CAP];

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cmd_word(input logic [7:0] c);
        return {8'h00, c};
    endfunction

    // strobe monitor: rebuilds the written stream
    bit          prev_wr = 1'b1;
    bit          seen_wr = 1'b0;
    int          lo_len = 0;
    int          hi_len = 0;
    logic [15:0] lo_db;
    logic        lo_rs;
    always @(negedge clk_i) begin
        if (in_rst) begin
            prev_wr = 1'b1; lo_len = 0; hi_len = 0;
        end else begin
            if (!lcd_wr_n_o) begin
                if (prev_wr) begin
                    if (seen_wr) chk(hi_len >= HI_CYCLES, "R5 high width", hi_len, HI_CYCLES);
                    chk(lcd_rst_n_o && !lcd_cs_n_o, "R1/R8 strobe outside reset with cs",
                        {lcd_rst_n_o, lcd_cs_n_o}, 2'b10);
                    lo_db = lcd_db_o;
                    lo_rs = lcd_rs_o;
                end else if (lcd_db_o != lo_db) begin
                    chk(1'b0, "R5 bus stable", lcd_db_o, lo_db);
                end
                lo_len++; hi_len = 0;
            end else begin
                if (!prev_wr) begin
                    chk(lo_len >= LO_CYCLES, "R5 low width", lo_len, LO_CYCLES);
                    chk(lcd_rd_n_o == 1'b1, "R2 read strobe high", lcd_rd_n_o, 1);
                    if (cap_n < CAP) begin
                        cap_rs[cap_n] = lo_rs;
                        cap_db[cap_n] = lo_db;
                        cap_n++;
                    end
                    seen_wr = 1'b1;
                end
                hi_len++; lo_len = 0;
            end
            prev_wr = lcd_wr_n_o;
        end
    end

    task automatic fill_rand(input int len);
        for (int k = 0; k < len; k++) wbuf[k] = 16'($urandom);
    endtask

    // one transaction; entered right after a falling edge
    task automatic do_txn(input logic [7:0] c, input int len, input bit chk_start);
        int base;
        int i;
        int guard;
        bit hold_ok;
        bit seq_ok;
        bit saw_sent;
        base = cap_n;
        cmd_i = c; len_i = 17'(len); data_i = (len > 0) ? wbuf[0] : 16'hdead;
        if (chk_start) begin
            @(negedge clk_i);
            chk(busy_o && !lcd_cs_n_o && !lcd_wr_n_o && !lcd_rs_o, "R3 start next clock",
                {busy_o, lcd_cs_n_o, lcd_wr_n_o, lcd_rs_o}, 4'b1000);
        end
        i = 0; guard = 0;
        while (i < len && guard < 20000) begin
            @(negedge clk_i); guard++;
            if (sent_o) begin
                chk(last_o == (i == len - 1), "R7 last on word", last_o, (i == len - 1));
                i++;
                data_i = (i < len) ? wbuf[i] : 16'($urandom);
            end else if (last_o && i != len - 1) begin
                chk(1'b0, "R7 early last", i, len - 1);
            end
        end
        chk(i == len, "R6 one pulse per word", i, len);
        guard = 0; saw_sent = 1'b0;
        while (!(cap_n == base + len + 1 && lcd_wr_n_o) && guard < 200) begin
            @(negedge clk_i); guard++;
            if (sent_o || (len == 0 && last_o)) saw_sent = 1'b1;
        end
        if (len == 0) chk(!saw_sent, "R10 no sent or last", saw_sent, 0);
        hold_ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk_i);
            if (!busy_o || lcd_cs_n_o || last_o || sent_o) hold_ok = 1'b0;
        end
        chk(hold_ok, "R9/R8 busy and cs held while cmd nonzero", hold_ok, 1);
        chk(cap_n == base + len + 1, "R4/R9 write count, no restart", cap_n - base, len + 1);
        chk(cap_rs[base] == 1'b0 && cap_db[base] == cmd_word(c), "R3 command cycle",
            {cap_rs[base], cap_db[base]}, {1'b0, cmd_word(c)});
        seq_ok = 1'b1;
        for (int k = 0; k < len; k++) begin
            if (cap_rs[base + 1 + k] !== 1'b1 || cap_db[base + 1 + k] !== wbuf[k]) begin
                seq_ok = 1'b0;
                chk(1'b0, "R4 data word", {cap_rs[base + 1 + k], cap_db[base + 1 + k]},
                    {1'b1, wbuf[k]});
            end
        end
        if (len > 0) chk(seq_ok, "R4 data sequence", seq_ok, 1);
        cmd_i = '0;
        @(negedge clk_i);
        chk(!busy_o && lcd_cs_n_o, "R9 busy falls after clear", {busy_o, lcd_cs_n_o}, 2'b01);
        @(negedge clk_i);
        @(negedge clk_i);
        chk(!busy_o && lcd_cs_n_o && lcd_wr_n_o, "R2 idle with zero cmd",
            {busy_o, lcd_cs_n_o, lcd_wr_n_o}, 3'b011);
    endtask

    bit done = 1'b0;
    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        int lens;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk_i);
        // present a command before power-up finishes (R1)
        wbuf[0] = 16'h0000; wbuf[1] = 16'h0000; wbuf[2] = 16'h0000; wbuf[3] = 16'h00ef;
        cmd_i = 8'h2a; len_i = 17'd4; data_i = wbuf[0];
        rst_i = 1'b0; in_rst = 1'b0;
        k = 0;
        while (!lcd_rst_n_o && k < 1000) begin
            if (busy_o || !lcd_wr_n_o) chk(1'b0, "R1 idle during reset", busy_o, 0);
            k++;
            @(negedge clk_i);
            if (k == 1) chk(lcd_on_o == 1'b1, "R1 power on", lcd_on_o, 1);
        end
        chk(k == RST_CYCLES, "R1 reset low width", k, RST_CYCLES);
        do_txn(8'h2a, 4, 1'b0);

        wbuf[0] = 16'h0000; wbuf[1] = 16'h0000; wbuf[2] = 16'h0001; wbuf[3] = 16'h003f;
        do_txn(8'h2b, 4, 1'b1);
        fill_rand(0);   do_txn(8'h11, 0, 1'b1);   // R10
        fill_rand(1);   do_txn(8'h2c, 1, 1'b1);
        fill_rand(300); do_txn(8'h2c, 300, 1'b1);
        for (int t = 0; t < 30; t++) begin
            lens = int'($urandom_range(0, 24));
            fill_rand(lens);
            do_txn(8'($urandom_range(1, 255)), lens, 1'b1);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule